// File: doc/BRIEF.md
# Dual-Channel ADC Scan Sequencer

This block sequences an external two-channel analog-to-digital converter that has no explicit sample-request line. A conversion starts only when the channel-select output moves away from zero. The block powers the converter up and waits a programmed settling time. It then converts channel 0 and channel 1 in turn and keeps the latest 10-bit result of each channel in its own output register.

After each pair of results, the block samples a filter-hit flag that is computed elsewhere. From this flag it decides whether to convert the next pair at once (continuous scanning) or to power the converter down for a programmed sleep time (periodic scanning).

In periodic mode, a counter tracks consecutive filter hits. Once that count exceeds a programmed threshold, the sequencer stays in continuous scanning so that the signal can be debounced more finely. When the low-power bit is clear, scanning is always continuous.

Top module: `adc_scan_seq`

## Requirements
- R1: Out of reset, and while `enable_i` is low, `adc_pd_o` is 1, `adc_sel_o` is 0 and both stored values are 0 until a capture occurs.
- R2: One cycle after `enable_i` is seen high in idle, and again after every sleep phase, `adc_pd_o` is 0. `adc_sel_o` stays 0 for exactly `pwrup_time_i` cycles (at least 1) before the first request. `adc_pd_o` is 0 whenever `adc_sel_o` is non-zero.
- R3: Channel-select encoding is channel number plus one: 0 means none, 1 means channel 0, 2 means channel 1. Each scan requests code 1 first and then code 2.
- R4: A non-zero code is held until `adc_valid_i` is sampled high. `adc_sel_o` then returns to 0 for at least one cycle before the next code, and it never changes directly from one non-zero code to another.
- R5: `chn0_val_o` / `chn1_val_o` take `adc_data_i` (10 bits) at the clock edge where `adc_valid_i` is high while code 1 / code 2 is driven. This holds even if `enable_i` falls in that same cycle. At all other times the stored values are unchanged, including on `adc_valid_i` pulses in idle.
- R6: The cycle after the channel-1 capture is an evaluation cycle: `adc_sel_o` is 0, `adc_pd_o` is 0, and `filter_hit_i` is sampled at its closing edge.
- R7: With `lp_mode_i` low at evaluation, the next cycle drives code 1 again, with `adc_pd_o` still 0.
- R8: With `lp_mode_i` high, each evaluation increments a hit counter on a hit (saturating) and clears it on a miss. The counter is also cleared while `lp_mode_i` is low. If the updated count exceeds `lp_sample_cnt_i`, scanning continues as in R7. Otherwise `adc_pd_o` is 1 for exactly `wakeup_time_i` cycles (at least 1), followed by the power-up phase of R2.
- R9: When `enable_i` is low, `adc_pd_o` is 1 and `adc_sel_o` is 0 in the next cycle, and the hit counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the sequencer; low forces idle |
| lp_mode_i | input | 1 | Allow periodic low-power scanning |
| pwrup_time_i | input | PWRUP_W | Power-up settling cycles |
| wakeup_time_i | input | WAKE_W | Sleep cycles between periodic scans |
| lp_sample_cnt_i | input | LP_W | Hit-count threshold for switching to continuous scanning |
| filter_hit_i | input | 1 | Filter result for the pair just taken |
| adc_data_i | input | DATA_W | Conversion result |
| adc_valid_i | input | 1 | Conversion result valid |
| adc_pd_o | output | 1 | Converter power-down, 1 = off |
| adc_sel_o | output | 2 | Channel request code |
| chn0_val_o | output | DATA_W | Latest channel 0 result |
| chn1_val_o | output | DATA_W | Latest channel 1 result |

## Verification
The collision that matters is `enable_i` falling in the same cycle that `adc_valid_i` answers a pending channel-0 request: shutdown and capture share one clock edge. The bench drives both at one falling edge while code 1 is held. It then expects idle outputs one cycle later together with the new channel-0 value. A following valid pulse in idle must leave the value untouched. The same disable also has to clear the hit counter, which the bench judges from whether the next periodic hit sleeps or keeps scanning.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_CH = 2;
  localparam int SEL_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_SAMP0,
    ST_GAP,
    ST_SAMP1,
    ST_EVAL,
    ST_SLEEP
  } scan_state_e;

  function automatic logic [SEL_W-1:0] chan_code(input int ch);
    return SEL_W'(ch + 1);
  endfunction
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  // last cycle of a phase; zero load behaves as one cycle
  assign done_o = (cnt_q <= W'(1));
endmodule

// File: rtl/adc_seq_lp_track.sv
module adc_seq_lp_track #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         eval_i,
  input  logic         hit_i,
  input  logic [W-1:0] thr_i,
  output logic         cont_o
);
  logic [W-1:0] cnt_q, cnt_inc;

  assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + W'(1);
  assign cont_o  = hit_i && (cnt_inc > thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (eval_i)  cnt_q <= hit_i ? cnt_inc : '0;
  end
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int              DATA_W = 10,
  parameter int              SEL_W  = 2,
  parameter logic [SEL_W-1:0] CODE  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        val_o <= '0;
    else if (valid_i && sel_i == CODE)  val_o <= data_i;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int PWRUP_W = 8,
  parameter int WAKE_W  = 12,
  parameter int LP_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              lp_mode_i,
  input  logic [PWRUP_W-1:0] pwrup_time_i,
  input  logic [WAKE_W-1:0] wakeup_time_i,
  input  logic [LP_W-1:0]   lp_sample_cnt_i,
  input  logic              filter_hit_i,
  input  logic [DATA_W-1:0] adc_data_i,
  input  logic              adc_valid_i,
  output logic              adc_pd_o,
  output logic [1:0]        adc_sel_o,
  output logic [DATA_W-1:0] chn0_val_o,
  output logic [DATA_W-1:0] chn1_val_o
);
  localparam int TMR_W = (PWRUP_W > WAKE_W) ? PWRUP_W : WAKE_W;

  scan_state_e      state_q, state_d;
  logic             tmr_load, tmr_done, go_cont, lp_eval, lp_clr;
  logic [TMR_W-1:0] tmr_val;
  logic [DATA_W-1:0] val [NUM_CH];

  adc_seq_timer #(.W(TMR_W)) u_timer (
    .clk_i, .rst_ni,
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .done_o    (tmr_done)
  );

  assign lp_eval = (state_q == ST_EVAL) && enable_i && lp_mode_i;
  assign lp_clr  = !enable_i || !lp_mode_i;

  adc_seq_lp_track #(.W(LP_W)) u_lp (
    .clk_i, .rst_ni,
    .clr_i (lp_clr),
    .eval_i(lp_eval),
    .hit_i (filter_hit_i),
    .thr_i (lp_sample_cnt_i),
    .cont_o(go_cont)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(pwrup_time_i);
    if (!enable_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d  = ST_PWRUP;
          tmr_load = 1'b1;
        end
        ST_PWRUP: if (tmr_done) state_d = ST_SAMP0;
        ST_SAMP0: if (adc_valid_i) state_d = ST_GAP;
        ST_GAP:   state_d = ST_SAMP1;
        ST_SAMP1: if (adc_valid_i) state_d = ST_EVAL;
        ST_EVAL: begin
          if (!lp_mode_i || go_cont) begin
            state_d = ST_SAMP0;
          end else begin
            state_d  = ST_SLEEP;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(wakeup_time_i);
          end
        end
        ST_SLEEP: if (tmr_done) begin
          state_d  = ST_PWRUP;
          tmr_load = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_SAMP0: adc_sel_o = chan_code(0);
      ST_SAMP1: adc_sel_o = chan_code(1);
      default:  adc_sel_o = '0;
    endcase
  end

  assign adc_pd_o = (state_q == ST_IDLE) || (state_q == ST_SLEEP);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cap
    adc_seq_capture #(
      .DATA_W(DATA_W), .SEL_W(SEL_W), .CODE(chan_code(c))
    ) u_cap (
      .clk_i, .rst_ni,
      .sel_i  (adc_sel_o),
      .valid_i(adc_valid_i),
      .data_i (adc_data_i),
      .val_o  (val[c])
    );
  end

  assign chn0_val_o = val[0];
  assign chn1_val_o = val[1];
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              adc_valid_i,
  input logic [DATA_W-1:0] adc_data_i,
  input logic              adc_pd_o,
  input logic [1:0]        adc_sel_o,
  input logic [DATA_W-1:0] chn0_val_o,
  input logic [DATA_W-1:0] chn1_val_o
);
  AST_SEL_NEEDS_POWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_sel_o != 2'd0 |-> !adc_pd_o); // R2
  AST_SEL_VIA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_sel_o != 2'd0 && $past(adc_sel_o) != 2'd0) |-> adc_sel_o == $past(adc_sel_o)); // R4
  AST_SEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_sel_o != 2'd0 && !adc_valid_i && enable_i) |=> adc_sel_o == $past(adc_sel_o)); // R4
  AST_CH0_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_sel_o == 2'd1 && adc_valid_i) |=> chn0_val_o == $past(adc_data_i)); // R5
  AST_CH1_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_sel_o == 2'd2 && adc_valid_i) |=> chn1_val_o == $past(adc_data_i)); // R5
  AST_CH0_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(adc_sel_o == 2'd1 && adc_valid_i) |=> $stable(chn0_val_o)); // R5
  AST_CH1_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(adc_sel_o == 2'd2 && adc_valid_i) |=> $stable(chn1_val_o)); // R5
  AST_DISABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (adc_pd_o && adc_sel_o == 2'd0)); // R9
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .adc_valid_i(adc_valid_i),
  .adc_data_i (adc_data_i),
  .adc_pd_o   (adc_pd_o),
  .adc_sel_o  (adc_sel_o),
  .chn0_val_o (chn0_val_o),
  .chn1_val_o (chn1_val_o)
);

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;
  localparam int PWR = 3;
  localparam int WAK = 5;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       enable_i = 1'b0, lp_mode_i = 1'b0, filter_hit_i = 1'b0, adc_valid_i = 1'b0;
  logic [7:0] pwrup_time_i = 8'(PWR);
  logic [11:0] wakeup_time_i = 12'(WAK);
  logic [7:0] lp_sample_cnt_i = 8'd2;
  logic [9:0] adc_data_i = '0;
  logic       adc_pd_o;
  logic [1:0] adc_sel_o;
  logic [9:0] chn0_val_o, chn1_val_o;

  int checks = 0, failures = 0;

  always #2 clk_i = ~clk_i;

  adc_scan_seq u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {lp, hit, expect_sleep, d0, d1}
  localparam logic [22:0] VEC [7] = '{
    {1'b1, 1'b1, 1'b1, 10'h155, 10'h2AA},
    {1'b1, 1'b1, 1'b1, 10'h3FF, 10'h000},
    {1'b1, 1'b1, 1'b0, 10'h001, 10'h200},
    {1'b1, 1'b1, 1'b0, 10'h123, 10'h321},
    {1'b1, 1'b0, 1'b1, 10'h0F0, 10'h30F},
    {1'b0, 1'b0, 1'b0, 10'h2B4, 10'h14B},
    {1'b1, 1'b1, 1'b1, 10'h07E, 10'h381}
  };

  task automatic count_pwrup();
    int m = 0;
    while (adc_sel_o == 2'd0 && m < 1000) begin
      if (adc_pd_o) check("R2 pd during power-up", 1, 0);
      m++;
      @(negedge clk_i);
    end
    check("R2 power-up length", m, PWR);
  endtask

  task automatic scan_round(input logic lp, input logic hit, input logic exp_sleep,
                            input logic [9:0] d0, input logic [9:0] d1, input string tag);
    int n = 0;
    lp_mode_i = lp;
    filter_hit_i = hit;
    while (adc_sel_o != 2'd1 && n < 1000) begin n++; @(negedge clk_i); end
    check("R3 first code", adc_sel_o, 1);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk_i);
      check("R4 code held", adc_sel_o, 1);
      check("R2 powered while requesting", adc_pd_o, 0);
    end
    adc_data_i = d0; adc_valid_i = 1'b1;
    @(negedge clk_i);
    adc_valid_i = 1'b0;
    check("R5 ch0 capture", chn0_val_o, d0);
    check("R4 return to zero", adc_sel_o, 0);
    @(negedge clk_i);
    check("R3 second code", adc_sel_o, 2);
    adc_data_i = d1; adc_valid_i = 1'b1;
    @(negedge clk_i);
    adc_valid_i = 1'b0;
    check("R5 ch1 capture", chn1_val_o, d1);
    check("R6 eval sel", adc_sel_o, 0);
    check("R6 eval pd", adc_pd_o, 0);
    @(negedge clk_i);
    if (exp_sleep) begin
      check({tag, " sleep entered"}, adc_pd_o, 1);
      n = 0;
      while (adc_pd_o && n < 1000) begin n++; @(negedge clk_i); end
      check("R8 sleep length", n, WAK);
      count_pwrup();
    end else begin
      check({tag, " continuous next code"}, adc_sel_o, 1);
      check({tag, " continuous stays powered"}, adc_pd_o, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset pd", adc_pd_o, 1);
    check("R1 reset sel", adc_sel_o, 0);
    check("R1 reset ch0", chn0_val_o, 0);
    check("R1 reset ch1", chn1_val_o, 0);
    // valid pulse while idle must be ignored
    adc_data_i = 10'h3FF; adc_valid_i = 1'b1;
    @(negedge clk_i);
    adc_valid_i = 1'b0;
    @(negedge clk_i);
    check("R1 idle pd", adc_pd_o, 1);
    check("R5 idle valid ignored ch0", chn0_val_o, 0);
    check("R5 idle valid ignored ch1", chn1_val_o, 0);

    enable_i = 1'b1;
    @(negedge clk_i);
    count_pwrup();

    foreach (VEC[i]) begin
      scan_round(VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:10], VEC[i][9:0],
                 VEC[i][20] ? "R8" : (VEC[i][22] ? "R8" : "R7"));
    end

    // hit counter now 1; threshold 1; code 1 pending.
    // Disable and valid in the same cycle.
    lp_sample_cnt_i = 8'd1;
    enable_i = 1'b0; adc_data_i = 10'h2C3; adc_valid_i = 1'b1;
    @(negedge clk_i);
    adc_valid_i = 1'b0;
    check("R9 disable pd", adc_pd_o, 1);
    check("R9 disable sel", adc_sel_o, 0);
    check("R5 capture on disable edge", chn0_val_o, 10'h2C3);
    adc_data_i = 10'h011; adc_valid_i = 1'b1;
    @(negedge clk_i);
    adc_valid_i = 1'b0;
    check("R5 idle valid ignored after disable", chn0_val_o, 10'h2C3);
    check("R1 idle after disable", adc_pd_o, 1);

    enable_i = 1'b1;
    @(negedge clk_i);
    count_pwrup();
    // cleared counter: hit gives 1, not above 1, so sleep
    scan_round(1'b1, 1'b1, 1'b1, 10'h0AA, 10'h155, "R9 counter cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule